// File: doc/BRIEF.md
# Serial EEPROM Write-Protocol Slave

This block is the write side of a two-wire serial EEPROM slave. A bus front end, which is not part of this block, turns the pad activity into single-cycle events: start, stop, and one strobe for every rising edge of the serial clock with the sampled data bit. From those events the block recognises the select byte, then a high and a low address byte, then any number of data bytes. For each byte it decides whether to acknowledge and presents that decision on `ack_o` during the acknowledge clock. The front end drives the data line from `ack_o`.

Data bytes are collected in a row buffer that holds one memory row. A stop that arrives at the start of a byte slot, right after a data byte has been acknowledged, hands the row to the array through a one-cycle commit port. After that, a write-cycle timer keeps the slave deaf and silent for a fixed number of clocks. When the timer expires, the internal address pointer moves to the byte that follows the last one written. A write-protect input, a mismatched select byte and a repeated start each stop data from reaching the array.

Top module: `eew_write_slave`

## Requirements
- R1: A select byte whose upper four bits equal `DEV_TYPE`, whose next three bits equal `chip_addr` and whose last bit is 0 is acknowledged. So are the two address bytes that follow it, high byte first. `ack_o` rises on the second clock edge after the eighth bit strobe of a byte and falls on the edge that takes the ninth strobe.
- R2: A select byte with a different type, a different chip address or the read bit set gets no acknowledge. No further byte is acknowledged until the next start.
- R3: The high address byte and bits 7..5 of the low byte form `cm_row`, the 16-bit address bits 15..5. Bits 4..0 of the low byte pick the byte in the row that receives the first data byte. `cm_data` byte k is bits 8k+7..8k, and `cm_mask` bit k marks it as written.
- R4: A commit pulse (`cm_valid`, one cycle) follows only a stop that arrives before any bit of a new byte, while data bytes are being received and at least one byte is held. A stop in the middle of a byte, or between the eighth bit and the acknowledge clock, discards the page.
- R5: The byte position advances by one after each accepted data byte and wraps from 31 to 0 within the same row. A later byte at a position overwrites the earlier one.
- R6: While `wp_i` is high, data bytes are not acknowledged and not stored, but select and address bytes are still acknowledged. A page with no stored byte does not commit and starts no write cycle.
- R7: `busy_o` is high for exactly `WRITE_CYCLES` clocks, starting with the cycle of `cm_valid`. While it is high, start, stop and bit strobes are ignored and `ack_o` stays low.
- R8: When `busy_o` falls, `ptr_o` becomes (row * 32 + last written position + 1) mod 65536. It changes at no other time.
- R9: A start received while a page is open discards every byte collected so far. The next commit holds only bytes that were written after that start.
- R10: After reset `ack_o`, `busy_o` and `cm_valid` are 0 and `ptr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_addr | input | 3 | Strapped chip address compared against the select byte |
| wp_i | input | 1 | Write protect: refuses data bytes |
| ev_start | input | 1 | Start or repeated start event, one cycle |
| ev_stop | input | 1 | Stop event, one cycle |
| bit_stb | input | 1 | Serial clock rising edge event, one cycle |
| bit_val | input | 1 | Data bit sampled with `bit_stb` |
| ack_o | output | 1 | Acknowledge request for the current byte |
| busy_o | output | 1 | Internal write cycle in progress |
| cm_valid | output | 1 | Commit pulse toward the array |
| cm_row | output | ROW_W (11) | Row address, address bits 15..5 |
| cm_data | output | ROW_BYTES*8 (256) | Row contents, byte k at bits 8k+7..8k |
| cm_mask | output | ROW_BYTES (32) | Written-byte mask |
| ptr_o | output | 16 | Internal address pointer |

## Verification
The assertions check on every cycle that the slave stays silent while busy and that each commit carries at least one byte and starts the busy window. They also check that the pointer only moves as busy falls, that the bit counter stays in range, that a clear leaves the row empty, and that protected or rejected bytes never raise an acknowledge. Other behaviour only the bench scenarios can show: which stop slot commits and which one discards, wrap and overwrite within a row, the exact busy length, the pointer value, and that a repeated start throws away the open page. The bench shows these by comparing each acknowledge and each commit against a model built from the requirements.

// File: rtl/eew_pkg.sv
`timescale 1ns/1ps
package eew_pkg;

    localparam int ADDR_W        = 16;
    localparam int BYTE_W        = 8;
    localparam int DEF_ROW_BYTES = 32;
    localparam logic [3:0] DEF_DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SELECT,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic [3:0] dev_type;
        logic [2:0] chip;
        logic       rd;
    } sel_t;

    function automatic logic sel_ok(sel_t s, logic [3:0] t, logic [2:0] c);
        return (s.dev_type == t) && (s.chip == c) && !s.rd;
    endfunction

endpackage

// File: rtl/eew_bit_rx.sv
`timescale 1ns/1ps
module eew_bit_rx
    import eew_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_rdy,
    output logic              ack_end,
    output logic              slot_zero
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q    <= '0;
            byte_rdy <= 1'b0;
            if (rst) byte_q <= '0;
        end else begin
            byte_rdy <= 1'b0;
            if (bit_stb) begin
                if (cnt_q < CNT_W'(BYTE_W)) begin
                    byte_q   <= {byte_q[BYTE_W-2:0], bit_val};
                    cnt_q    <= cnt_q + 1'b1;
                    byte_rdy <= (cnt_q == CNT_W'(BYTE_W - 1));
                end else begin
                    cnt_q <= '0;
                end
            end
        end
    end

    // the strobe after the eighth data bit is the acknowledge clock
    assign ack_end   = bit_stb && (cnt_q == CNT_W'(BYTE_W));
    assign slot_zero = (cnt_q == '0);

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(BYTE_W)) else $error("bit counter out of range"); // R4
    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        byte_rdy |=> !byte_rdy) else $error("byte ready held"); // R1

endmodule

// File: rtl/eew_row_buf.sv
`timescale 1ns/1ps
module eew_row_buf
    import eew_pkg::*;
#(
    parameter int ROW_BYTES = DEF_ROW_BYTES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        wr,
    input  logic [$clog2(ROW_BYTES)-1:0] col,
    input  logic [BYTE_W-1:0]           din,
    output logic [ROW_BYTES*BYTE_W-1:0] data,
    output logic [ROW_BYTES-1:0]        mask,
    output logic                        any
);
    localparam int COL_W = $clog2(ROW_BYTES);

    logic [BYTE_W-1:0] mem_q  [ROW_BYTES];
    logic              mark_q [ROW_BYTES];

    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g]  <= '0;
                mark_q[g] <= 1'b0;
            end else if (clr) begin
                mark_q[g] <= 1'b0;
            end else if (wr && (col == COL_W'(g))) begin
                mem_q[g]  <= din;
                mark_q[g] <= 1'b1;
            end
        end
        assign data[g*BYTE_W +: BYTE_W] = mem_q[g];
        assign mask[g]                  = mark_q[g];
    end

    assign any = |mask;

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (mask == '0)) else $error("row not emptied"); // R9

endmodule

// File: rtl/eew_busy_timer.sv
`timescale 1ns/1ps
module eew_busy_timer #(
    parameter int WRITE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load && (cnt_q == '0)) begin
            cnt_q <= CW'(WRITE_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (load && !busy) |=> busy) else $error("load did not start timer"); // R7
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy) else $error("busy ended early"); // R7

endmodule

// File: rtl/eew_write_slave.sv
`timescale 1ns/1ps
module eew_write_slave
    import eew_pkg::*;
#(
    parameter int         ROW_BYTES    = DEF_ROW_BYTES,
    parameter logic [3:0] DEV_TYPE     = DEF_DEV_TYPE,
    parameter int         WRITE_CYCLES = 1000
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic [2:0]                                    chip_addr,
    input  logic                                          wp_i,
    input  logic                                          ev_start,
    input  logic                                          ev_stop,
    input  logic                                          bit_stb,
    input  logic                                          bit_val,
    output logic                                          ack_o,
    output logic                                          busy_o,
    output logic                                          cm_valid,
    output logic [eew_pkg::ADDR_W-$clog2(ROW_BYTES)-1:0]  cm_row,
    output logic [ROW_BYTES*eew_pkg::BYTE_W-1:0]          cm_data,
    output logic [ROW_BYTES-1:0]                          cm_mask,
    output logic [eew_pkg::ADDR_W-1:0]                    ptr_o
);
    localparam int COL_W = $clog2(ROW_BYTES);
    localparam int ROW_W = ADDR_W - COL_W;

    // bus events are dropped entirely during the write cycle
    logic g_start, g_stop, g_bit;
    assign g_start = ev_start && !busy_o;
    assign g_stop  = ev_stop  && !busy_o;
    assign g_bit   = bit_stb  && !busy_o;

    logic [BYTE_W-1:0] rx_byte;
    logic              rx_rdy, rx_ack_end, rx_slot0;

    eew_bit_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .clr      (g_start || g_stop),
        .bit_stb  (g_bit),
        .bit_val  (bit_val),
        .byte_q   (rx_byte),
        .byte_rdy (rx_rdy),
        .ack_end  (rx_ack_end),
        .slot_zero(rx_slot0)
    );

    phase_e            phase_q;
    logic              ack_q;
    logic [BYTE_W-1:0] hi_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q, last_col_q;
    logic [ADDR_W-1:0] ptr_q, ptr_pend_q;
    logic              cm_valid_q;

    logic buf_wr, buf_any, commit_fire, tmr_done;

    assign buf_wr = rx_rdy && (phase_q == PH_DATA) && !wp_i && !g_start && !g_stop;

    eew_row_buf #(.ROW_BYTES(ROW_BYTES)) u_buf (
        .clk (clk),
        .rst (rst),
        .clr (g_start),
        .wr  (buf_wr),
        .col (col_q),
        .din (rx_byte),
        .data(cm_data),
        .mask(cm_mask),
        .any (buf_any)
    );

    // tenth-slot stop: receiver at bit zero while collecting data
    assign commit_fire = g_stop && (phase_q == PH_DATA) && rx_slot0 && buf_any;

    eew_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_tmr (
        .clk (clk),
        .rst (rst),
        .load(commit_fire),
        .busy(busy_o),
        .done(tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            ack_q      <= 1'b0;
            hi_q       <= '0;
            row_q      <= '0;
            col_q      <= '0;
            last_col_q <= '0;
            ptr_q      <= '0;
            ptr_pend_q <= '0;
            cm_valid_q <= 1'b0;
        end else begin
            cm_valid_q <= commit_fire;
            if (commit_fire) ptr_pend_q <= {row_q, last_col_q} + ADDR_W'(1);
            if (tmr_done)    ptr_q      <= ptr_pend_q;

            if (g_start) begin
                phase_q <= PH_SELECT;
                ack_q   <= 1'b0;
            end else if (g_stop) begin
                phase_q <= PH_IDLE;
                ack_q   <= 1'b0;
            end else if (rx_ack_end) begin
                ack_q <= 1'b0;
            end else if (rx_rdy) begin
                unique case (phase_q)
                    PH_SELECT: begin
                        if (sel_ok(sel_t'(rx_byte), DEV_TYPE, chip_addr)) begin
                            ack_q   <= 1'b1;
                            phase_q <= PH_ADDR_HI;
                        end else begin
                            ack_q   <= 1'b0;
                            phase_q <= PH_IDLE;
                        end
                    end
                    PH_ADDR_HI: begin
                        hi_q    <= rx_byte;
                        ack_q   <= 1'b1;
                        phase_q <= PH_ADDR_LO;
                    end
                    PH_ADDR_LO: begin
                        row_q   <= {hi_q, rx_byte[BYTE_W-1:COL_W]};
                        col_q   <= rx_byte[COL_W-1:0];
                        ack_q   <= 1'b1;
                        phase_q <= PH_DATA;
                    end
                    PH_DATA: begin
                        if (!wp_i) begin
                            last_col_q <= col_q;
                            col_q      <= col_q + 1'b1;
                            ack_q      <= 1'b1;
                        end else begin
                            ack_q <= 1'b0;
                        end
                    end
                    default: ack_q <= 1'b0;
                endcase
            end
        end
    end

    assign ack_o    = ack_q;
    assign cm_valid = cm_valid_q;
    assign cm_row   = row_q;
    assign ptr_o    = ptr_q;

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !ack_o) else $error("acknowledge during write cycle"); // R7
    AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cm_valid |-> busy_o) else $error("commit without busy"); // R7
    AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        cm_valid |-> (cm_mask != '0)) else $error("empty commit"); // R4
    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy_o) |-> $stable(ptr_o)) else $error("pointer moved early"); // R8
    AST_WP_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (wp_i && rx_rdy && phase_q == PH_DATA && !ev_start && !ev_stop) |=> !ack_o)
        else $error("protected byte acknowledged"); // R6
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (rx_rdy && phase_q == PH_IDLE && !ev_start && !ev_stop) |=> !ack_o)
        else $error("byte acknowledged after rejection"); // R2

endmodule

// File: tb/eew_write_slave_test.sv
`timescale 1ns/1ps
module eew_write_slave_test;

    localparam int WCYC = 150;
    localparam logic [7:0] SEL_W = 8'hAA;   // type 1010, chip 101, write

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wp = 1'b0, ev_start = 1'b0, ev_stop = 1'b0, bit_stb = 1'b0, bit_val = 1'b0;
    logic [2:0] chip = 3'b101;
    logic ack, busy, cmv;
    logic [10:0]  cm_row;
    logic [255:0] cm_data;
    logic [31:0]  cm_mask;
    logic [15:0]  ptr;

    always #10 clk = ~clk;

    eew_write_slave #(.WRITE_CYCLES(WCYC)) uut (
        .clk(clk), .rst(rst), .chip_addr(chip), .wp_i(wp),
        .ev_start(ev_start), .ev_stop(ev_stop), .bit_stb(bit_stb), .bit_val(bit_val),
        .ack_o(ack), .busy_o(busy), .cm_valid(cmv), .cm_row(cm_row),
        .cm_data(cm_data), .cm_mask(cm_mask), .ptr_o(ptr)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [10:0]  row;
        logic [31:0]  mask;
        logic [255:0] data;
        string        req;
    } cm_t;

    cm_t   cm_q[$];
    logic  ack_q[$];
    string ackr_q[$];

    logic [10:0]  e_row;
    logic [4:0]   e_col, e_last;
    logic [31:0]  e_mask;
    logic [255:0] e_data;
    logic [15:0]  e_ptr = 16'h0;
    int busy_neg = 0;
    int mcnt = 0;

    // driver
    task automatic pulse(input int kind, input logic b);
        @(posedge clk); #2;
        if (kind == 0) ev_start = 1'b1;
        else if (kind == 1) ev_stop = 1'b1;
        else begin bit_stb = 1'b1; bit_val = b; end
        @(posedge clk); #2;
        ev_start = 1'b0; ev_stop = 1'b0; bit_stb = 1'b0; bit_val = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) pulse(2, b[i]);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        ack_q.push_back(exp_ack);
        ackr_q.push_back(req);
        send_bits(b, 8);
        pulse(2, 1'b1);
    endtask

    task automatic open_page(input logic [15:0] a, input string req);
        pulse(0, 1'b0);
        send_byte(SEL_W, 1'b1, req);
        send_byte(a[15:8], 1'b1, req);
        send_byte(a[7:0], 1'b1, req);
        e_row = a[15:5]; e_col = a[4:0]; e_mask = '0; e_data = '0;
    endtask

    task automatic data_byte(input logic [7:0] b, input string req);
        send_byte(b, !wp, req);
        if (!wp) begin
            e_data[int'(e_col)*8 +: 8] = b;
            e_mask[e_col] = 1'b1;
            e_last = e_col;
            e_col = e_col + 5'd1;
        end
    endtask

    task automatic close_commit(input string req);
        cm_t c;
        c.row = e_row; c.mask = e_mask; c.data = e_data; c.req = req;
        cm_q.push_back(c);
        e_ptr = {e_row, e_last} + 16'd1;
        pulse(1, 1'b0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        logic         e;
        string        r;
        cm_t          c;
        logic [255:0] bm;
        if (!rst) begin
            if (busy) busy_neg++;
            if (ev_start || ev_stop) mcnt = 0;
            else if (bit_stb) begin
                mcnt++;
                if (mcnt == 9) begin
                    mcnt = 0;
                    if (ack_q.size() == 0) check(1'b0, "R1", "unexpected ack slot", ack, 0);
                    else begin
                        e = ack_q.pop_front();
                        r = ackr_q.pop_front();
                        check(ack === e, r, "acknowledge", ack, e);
                    end
                end
            end
            if (cmv) begin
                if (cm_q.size() == 0) check(1'b0, "R4", "unexpected commit", cmv, 0);
                else begin
                    c = cm_q.pop_front();
                    bm = '0;
                    for (int k = 0; k < 32; k++) if (c.mask[k]) bm[k*8 +: 8] = 8'hFF;
                    check(cm_row == c.row, c.req, "commit row (R3)", cm_row, c.row);
                    check(cm_mask == c.mask, c.req, "commit mask", cm_mask, c.mask);
                    check((cm_data & bm) == c.data, c.req, "commit data", cm_data & bm, c.data);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(ack == 1'b0,  "R10", "ack after reset", ack, 0);
        check(busy == 1'b0, "R10", "busy after reset", busy, 0);
        check(cmv == 1'b0,  "R10", "commit after reset", cmv, 0);
        check(ptr == 16'h0, "R10", "pointer after reset", ptr, 0);

        // R1 R3 single byte, R7 busy length, R8 pointer
        open_page(16'h1234, "R1");
        data_byte(8'hA5, "R3");
        busy_neg = 0;
        close_commit("R3");
        wait_idle();
        check(busy_neg == WCYC, "R7", "busy length", busy_neg, WCYC);
        check(ptr == e_ptr, "R8", "pointer after byte write", ptr, e_ptr);

        // R5 wrap across row end
        open_page(16'h0ABE, "R5");
        for (int i = 0; i < 5; i++) data_byte(8'h10 + 8'(i), "R5");
        close_commit("R5");
        wait_idle();
        check(ptr == e_ptr, "R8", "pointer after wrapped page", ptr, e_ptr);

        // R5 overwrite: 34 bytes into a 32-byte row
        open_page(16'h2000, "R5");
        for (int i = 0; i < 34; i++) data_byte(8'(i * 7 + 3), "R5");
        close_commit("R5");
        wait_idle();
        check(ptr == e_ptr, "R8", "pointer after overwrite", ptr, e_ptr);

        // R6 write protect
        wp = 1'b1;
        open_page(16'h0400, "R6");
        data_byte(8'h55, "R6");
        data_byte(8'h66, "R6");
        pulse(1, 1'b0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R6", "busy after protected page", busy, 0);
        check(ptr == e_ptr, "R6", "pointer after protected page", ptr, e_ptr);
        wp = 1'b0;

        // R4 stops outside the tenth slot
        open_page(16'h0600, "R4");
        data_byte(8'h11, "R4");
        send_bits(8'h5C, 4);
        pulse(1, 1'b0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R4", "busy after mid-byte stop", busy, 0);
        open_page(16'h0600, "R4");
        data_byte(8'h22, "R4");
        send_bits(8'h33, 8);
        pulse(1, 1'b0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R4", "busy after stop before ack clock", busy, 0);
        open_page(16'h0600, "R4");
        pulse(1, 1'b0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R4", "busy after address-only stop", busy, 0);

        // R2 rejected select bytes
        pulse(0, 1'b0);
        send_byte(8'h5A, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        pulse(1, 1'b0);
        pulse(0, 1'b0);
        send_byte(8'hAB, 1'b0, "R2");
        pulse(1, 1'b0);
        pulse(0, 1'b0);
        send_byte(8'hA2, 1'b0, "R2");
        send_byte(8'h12, 1'b0, "R2");
        pulse(1, 1'b0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R2", "busy after rejected selects", busy, 0);

        // R9 repeated start aborts open page
        open_page(16'h0100, "R9");
        data_byte(8'hE1, "R9");
        data_byte(8'hE2, "R9");
        open_page(16'h0345, "R9");
        data_byte(8'hC3, "R9");
        close_commit("R9");
        wait_idle();
        check(ptr == e_ptr, "R8", "pointer after aborted page", ptr, e_ptr);

        // R7 traffic during write cycle is ignored
        open_page(16'h7FFF, "R7");
        data_byte(8'h9E, "R7");
        close_commit("R7");
        pulse(0, 1'b0);
        send_byte(SEL_W, 1'b0, "R7");
        send_byte(8'h00, 1'b0, "R7");
        pulse(1, 1'b0);
        @(negedge clk);
        check(busy == 1'b1, "R7", "busy still high during traffic", busy, 1);
        wait_idle();
        check(ptr == 16'h8000, "R8", "pointer past top address", ptr, 16'h8000);

        repeat (10) @(negedge clk);
        check(cm_q.size() == 0, "R4", "missing commits", cm_q.size(), 0);
        check(ack_q.size() == 0, "R1", "unchecked ack slots", ack_q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule